// File: doc/BRIEF.md
# Column block distributor

This block feeds one column of processing units from a serial stream of blocks. Each block is a fixed number of 64-bit beats (54 by default, enough for 108 32-bit words). A head buffer at the top of the column keeps the first blocks of each block cycle, one per unit in its column, and hands every later block of that cycle unchanged to the column on its right. Identical columns can therefore be chained left to right, and the stream spreads itself across them with no central controller.

Below the head sits a chain of routers, one in front of each unit. Once the head holds a full set of blocks, it drains them downward. Each router claims the first block that reaches it in the current cycle and writes that block into its unit's buffer. It forwards every later beat to the router below. A claimed router raises a ready-block flag for its unit. A one-clock cycle-start pulse clears all claims and counters, so the pattern repeats every block cycle. Incoming blocks for the next cycle may arrive while the units are still busy. The pulse is meant to be given only after the previous distribution has finished.

Top module: `blk_col_feeder`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, u_we is all zero and blk_rdy is all zero.
- R2: In each block cycle the first N_UNITS blocks accepted at the input are kept in the column. While they are being kept, in_ready stays 1 whatever out_ready is.
- R3: Every block after the first N_UNITS in a cycle appears at out_data unchanged and in order. While such a block is being passed, out_valid follows in_valid and in_ready follows out_ready.
- R4: No unit write (u_we bit high) occurs before the last beat of the N_UNITS-th kept block of the cycle has been accepted.
- R5: Unit k, counted from 0 at the top, receives the k-th kept block of the cycle. Its beats arrive in order with u_addr slice k (bits k*BW upward, BW = clog2(BEATS)) counting 0 to BEATS-1, and u_data equals the input beat.
- R6: blk_rdy[k] is 0 while unit k receives its last beat and is 1 on the next clock. It then holds until a cycle-start pulse.
- R7: During a cycle_start clock in_ready is 0 and no unit write occurs. On the clock after it, blk_rdy is all zero and a new cycle of keeping begins.
- R8: At most one u_we bit is high in any clock, and never the bit of a unit whose blk_rdy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cycle_start | input | 1 | One-clock pulse that opens a new block cycle |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DW | Input beat |
| out_valid | output | 1 | Beat valid toward the next column |
| out_ready | input | 1 | Next column accepts the beat |
| out_data | output | DW | Beat toward the next column |
| u_we | output | N_UNITS | Per-unit buffer write enable |
| u_addr | output | N_UNITS*BW | Per-unit beat index within the block |
| u_data | output | DW | Beat written to the enabled unit |
| blk_rdy | output | N_UNITS | Per-unit flag: block fully captured this cycle |

## Verification
An input beat is taken on the rising edge where in_valid and in_ready are both high. Passing to the right is combinational, so a passed beat is visible at the output in the same clock. The first unit write appears in the clock after the edge that accepts the last kept beat, because the head's drain flag and FIFO entry register on that edge. Each ready-block flag rises one clock after its unit's last write, and the cycle-start pulse clears the flags one clock after the pulse. The bench drives inputs after the falling edge and samples just before the next rising edge, so each observation lands in the clock where the result is due. Writes and flags are compared beat by beat against the clock count since the fill edge.

// File: rtl/blk_col_feeder.sv
module blk_col_feeder #(
  parameter int N_UNITS = 3,
  parameter int BEATS   = 54,
  parameter int DW      = 64,
  localparam int BW     = $clog2(BEATS),
  localparam int DEPTH  = N_UNITS * BEATS,
  localparam int PW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int KW     = $clog2(N_UNITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cycle_start,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DW-1:0]         in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DW-1:0]         out_data,
  output logic [N_UNITS-1:0]    u_we,
  output logic [N_UNITS*BW-1:0] u_addr,
  output logic [DW-1:0]         u_data,
  output logic [N_UNITS-1:0]    blk_rdy
);

  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);
  localparam logic [KW-1:0] ALL_KEPT  = KW'(N_UNITS);
  localparam logic [KW-1:0] LAST_KEPT = KW'(N_UNITS - 1);
  localparam logic [PW-1:0] LAST_PTR  = PW'(DEPTH - 1);

  logic [KW-1:0] kept;
  logic [BW-1:0] in_beat;
  logic          keeping, wr, rd, drain, fifo_v;
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [N_UNITS:0] cv, cr;

  assign keeping   = kept != ALL_KEPT;
  assign in_ready  = !cycle_start && (keeping || out_ready);
  assign out_valid = !cycle_start && !keeping && in_valid;
  assign out_data  = in_data;
  assign wr        = in_valid && in_ready && keeping;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept    <= '0;
      in_beat <= '0;
      drain   <= 1'b0;
    end else if (cycle_start) begin
      kept    <= '0;
      in_beat <= '0;
      drain   <= 1'b0;
    end else if (in_valid && in_ready) begin
      if (in_beat == LAST_BEAT) begin
        in_beat <= '0;
        if (keeping) kept <= kept + 1'b1;
        if (keeping && kept == LAST_KEPT) drain <= 1'b1;
      end else begin
        in_beat <= in_beat + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (rd) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (wr && !rd)      cnt <= cnt + 1'b1;
      else if (rd && !wr) cnt <= cnt - 1'b1;
    end
  end

  assign fifo_v = drain && !cycle_start && (cnt != '0);
  assign cv[0]  = fifo_v;
  assign rd     = fifo_v && cr[0];
  assign cr[N_UNITS] = 1'b0;
  assign u_data = mem[rd_ptr];

  for (genvar k = 0; k < N_UNITS; k++) begin : g_rt
    logic [BW-1:0] bcnt;
    assign u_we[k]  = cv[k] && !blk_rdy[k];
    assign cv[k+1]  = cv[k] && blk_rdy[k];
    assign cr[k]    = blk_rdy[k] ? cr[k+1] : 1'b1;
    assign u_addr[k*BW +: BW] = bcnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bcnt       <= '0;
        blk_rdy[k] <= 1'b0;
      end else if (cycle_start) begin
        bcnt       <= '0;
        blk_rdy[k] <= 1'b0;
      end else if (u_we[k]) begin
        if (bcnt == LAST_BEAT) begin
          bcnt       <= '0;
          blk_rdy[k] <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

endmodule

module blk_col_feeder_chk #(
  parameter int N_UNITS = 3,
  parameter int BEATS   = 54,
  parameter int DW      = 64,
  localparam int BW     = $clog2(BEATS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cycle_start,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [N_UNITS-1:0]    u_we,
  input logic [N_UNITS-1:0]    blk_rdy
);

  AST_CS_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> !in_ready && (u_we == '0)); // R7

  AST_CS_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> blk_rdy == '0); // R7

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> ((blk_rdy & $past(blk_rdy)) == $past(blk_rdy))); // R6

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(u_we)); // R8

  AST_NO_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (u_we & blk_rdy) == '0); // R8

  AST_PASS_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ready == out_ready) && in_valid); // R3

endmodule

bind blk_col_feeder blk_col_feeder_chk #(.N_UNITS(N_UNITS), .BEATS(BEATS), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .u_we(u_we), .blk_rdy(blk_rdy)
);

// File: tb/blk_col_feeder_tb_top.sv
`timescale 1ns/1ps
module blk_col_feeder_tb_top;
  localparam int N  = 3;
  localparam int BT = 54;
  localparam int DW = 64;
  localparam int BW = $clog2(BT);

  logic clk = 1'b0, rst_n = 1'b0, cycle_start = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, in_ready, out_valid;
  logic [DW-1:0] in_data = '0, out_data, u_data;
  logic [N-1:0] u_we, blk_rdy;
  logic [N*BW-1:0] u_addr;

  always #2.5 clk = ~clk;

  blk_col_feeder #(.N_UNITS(N), .BEATS(BT), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .u_we(u_we), .u_addr(u_addr), .u_data(u_data), .blk_rdy(blk_rdy));

  int checks = 0, bad = 0;
  int cur_cyc = 0;
  bit filled = 0;
  bit stall_mode = 0;
  int sc = 0;
  int ub [N];
  bit lastw [N];
  int ob = 0;

  function automatic logic [DW-1:0] pat(input int c, input int b, input int t);
    return {32'hA5C3_1E77, 8'(c), 8'(b), 16'(t)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    sc++;
    out_ready <= !stall_mode || (sc % 3 != 0);
  end

  always begin
    @(negedge clk);
    #2;
    if (rst_n && !cycle_start) begin
      for (int k = 0; k < N; k++) begin
        if (lastw[k]) begin
          chk(blk_rdy[k], "R6", "flag one clock after last write", blk_rdy[k], 1);
          lastw[k] = 0;
        end
        if (u_we[k]) begin
          chk(filled, "R4", "unit write before fill", 1, 0);
          chk(u_addr[k*BW +: BW] == BW'(ub[k]), "R5", "unit beat index",
              u_addr[k*BW +: BW], ub[k]);
          chk(u_data == pat(cur_cyc, k, ub[k]), "R5", "unit beat data",
              u_data, pat(cur_cyc, k, ub[k]));
          if (ub[k] == BT - 1) begin
            chk(!blk_rdy[k], "R6", "flag low during last write", blk_rdy[k], 0);
            lastw[k] = 1;
          end
          ub[k]++;
        end
      end
      chk($countones(u_we) <= 1, "R8", "simultaneous unit writes", u_we, 0);
      if (out_valid) begin
        chk(in_ready == out_ready, "R3", "in_ready follows out_ready", in_ready, out_ready);
        if (out_ready) begin
          chk(out_data == pat(cur_cyc, N + ob / BT, ob % BT), "R3", "passed beat",
              out_data, pat(cur_cyc, N + ob / BT, ob % BT));
          ob++;
        end
      end
    end
  end

  task automatic put(input int c, input int b, input int t, output int waits);
    bit done = 0;
    waits = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data = pat(c, b, t);
    while (!done) begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        done = 1;
      end else begin
        @(negedge clk);
        waits++;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    #2;
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(u_we == '0, "R1", "u_we after reset", u_we, 0);
    chk(blk_rdy == '0, "R1", "blk_rdy after reset", blk_rdy, 0);
  endtask

  task automatic t_start();
    @(negedge clk);
    cycle_start = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R7", "in_ready during cycle start", in_ready, 0);
    @(negedge clk);
    cycle_start = 1'b0;
    #1;
    chk(blk_rdy == '0, "R7", "flags cleared after cycle start", blk_rdy, 0);
  endtask

  task automatic t_cycle(input int c, input int extra, input bit stall);
    int w, kw, ew;
    t_start();
    cur_cyc = c;
    filled = 0;
    ob = 0;
    for (int k = 0; k < N; k++) begin ub[k] = 0; lastw[k] = 0; end
    stall_mode = stall;
    kw = 0;
    for (int b = 0; b < N; b++)
      for (int t = 0; t < BT; t++) begin
        put(c, b, t, w);
        kw += w;
        if (b == N - 1 && t == BT - 1) filled = 1;
      end
    chk(kw == 0, "R2", "stalls while keeping", kw, 0);
    ew = 0;
    for (int b = N; b < N + extra; b++)
      for (int t = 0; t < BT; t++) begin
        put(c, b, t, w);
        ew += w;
      end
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < N * BT + 20 && blk_rdy != '1; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(blk_rdy == '1, "R6", "all flags set", blk_rdy, '1);
    for (int k = 0; k < N; k++)
      chk(ub[k] == BT, "R5", "beats per unit", ub[k], BT);
    chk(ob == extra * BT, "R3", "passed beat count", ob, extra * BT);
    if (stall && extra > 0)
      chk(ew > 0, "R3", "backpressure seen at input", ew, 1);
    stall_mode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    checks++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cycle(1, 2, 0);
    t_cycle(2, 2, 1);
    t_cycle(3, 0, 0);
    t_cycle(4, 1, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule